// File: doc/BRIEF.md
# Selectable Tick Source with Two-Stage Divider

This block produces a slow tick strobe for an always-on controller domain. Everything runs on one fast system clock. Four single-cycle "tick" strobes arrive on `src_tick`, and each one stands for a candidate source clock:

- index 0: a slow crystal
- index 1: the main oscillator
- index 2: a peripheral PLL
- index 3: a fourth source that depends on the variant

A 32-bit configuration word picks one source and programs two cascaded tick-counting dividers. Software writes that word through a bit-masked register port, so it can change one field without disturbing the others. The block drives `out_tick` once every N selected input ticks, where N is the total division.

The first divider stage is a pre-divider. It is in the path only when the peripheral PLL (index 2) is the selected source. The second stage is a ratio divider that always applies. A build-time parameter decides how the ratio field is decoded: either linearly or as a power of two. Any write to the register restarts both dividers from zero, so a new setting takes effect cleanly.

Each divider stage is a two-state machine, and its state is held alongside its count and its latched divisor. The two states are:

- `DV_PASS`: the divisor is 1, so the input strobe passes straight through in the same cycle.
- `DV_COUNT`: the stage counts input ticks and emits on the last one of each period.

There are three transitions:

- **load-to-pass**: a write whose new divisor is 1.
- **load-to-count**: a write whose new divisor is greater than 1.
- **hold**: no write. In `DV_COUNT` the counter advances on each input tick and wraps at the divisor.

Top module: `srcdiv_top`

## Requirements
- R1: After reset the register reads 0x0001_0000. That is source 1, with both divide fields at zero, so the total division is 1.
- R2: Bits 17:16 hold the source index. Value k routes `src_tick[k]` into the dividers, and the index reads back from the same bits.
- R3: Bits 12:8 hold the pre-divider field. Its factor is the field value plus one (1..32), and it applies only when the source index is 2. Every other source bypasses it.
- R4: Bits 5:4 hold the ratio field. It applies after the pre-divider for every source. With `POW2_RATIO`=0 its factor is the field value plus one (1..4).
- R5: With `POW2_RATIO`=1 the ratio factor is 2 raised to the field value (1, 2, 4 or 8).
- R6: A write updates only the bits whose `wr_mask` bit is 1. A write masked to bits 17:16 leaves every other bit unchanged.
- R7: All bits outside 17:16, 12:8 and 5:4 read as zero and ignore writes.
- R8: `out_tick` pulses in the same cycle as the selected input tick that completes a division period. When the total division is 1, `out_tick` equals the selected tick in every cycle without a write.
- R9: `out_tick` is low in every cycle with `wr_en`=1. After any write, the first output comes on exactly the N-th selected tick, where N is the new total division.
- R10: Ticks on sources that are not selected have no effect on `out_tick`. Over a window, the output count equals floor(selected ticks / N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| rd_data | output | 32 | Current register contents |
| src_tick | input | 4 | One tick strobe per candidate source |
| out_tick | output | 1 | Divided output tick |

## Verification
The assertions check the following in every cycle:

- undefined bits always read zero;
- the reset word appears when reset is released;
- a write masked to the source field preserves the other bits;
- the output is silent during writes;
- every output tick coincides with a tick on the selected source;
- with unity division the output mirrors the selected source exactly.

The actual division ratios can be shown only by the bench's windows. These include the pre-divider bypass for sources other than the PLL, the linear and power-of-two ratio decodes, and the exact position of the first output after a write that interrupts a partial period.

// File: rtl/srcdiv_pkg.sv
package srcdiv_pkg;

    localparam int WORD_W  = 32;
    localparam int SEL_LSB = 16;
    localparam int SEL_W   = 2;
    localparam int PRE_LSB = 8;
    localparam int PRE_W   = 5;
    localparam int RAT_LSB = 4;
    localparam int RAT_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;

    // Wide enough for (2^PRE_W) and for 2^(2^RAT_W - 1).
    localparam int DIV_W = ((PRE_W + 1) > ((1 << RAT_W) + 1)) ? (PRE_W + 1) : ((1 << RAT_W) + 1);

    localparam logic [SEL_W-1:0] SRC_PLL   = SEL_W'(2);
    localparam logic [SEL_W-1:0] SRC_RESET = SEL_W'(1);

    localparam logic [WORD_W-1:0] SEL_MASK = ((WORD_W'(1) << SEL_W) - 1) << SEL_LSB;
    localparam logic [WORD_W-1:0] PRE_MASK = ((WORD_W'(1) << PRE_W) - 1) << PRE_LSB;
    localparam logic [WORD_W-1:0] RAT_MASK = ((WORD_W'(1) << RAT_W) - 1) << RAT_LSB;
    localparam logic [WORD_W-1:0] DEF_MASK = SEL_MASK | PRE_MASK | RAT_MASK;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PRE_W-1:0] pre;
        logic [RAT_W-1:0] ratio;
    } cfg_t;

    typedef enum logic {
        DV_PASS  = 1'b0,
        DV_COUNT = 1'b1
    } dv_state_e;

    localparam cfg_t CFG_RESET = '{sel: SRC_RESET, pre: '0, ratio: '0};

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEL_LSB +: SEL_W] = c.sel;
        w[PRE_LSB +: PRE_W] = c.pre;
        w[RAT_LSB +: RAT_W] = c.ratio;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.sel   = w[SEL_LSB +: SEL_W];
        c.pre   = w[PRE_LSB +: PRE_W];
        c.ratio = w[RAT_LSB +: RAT_W];
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] pre_factor(input cfg_t c);
        if (c.sel == SRC_PLL)
            return DIV_W'(c.pre) + DIV_W'(1);
        return DIV_W'(1);
    endfunction

    function automatic logic [DIV_W-1:0] ratio_factor(input cfg_t c, input bit pow2);
        if (pow2)
            return DIV_W'(1) << c.ratio;
        return DIV_W'(c.ratio) + DIV_W'(1);
    endfunction

endpackage

// File: rtl/srcdiv_cfg_reg.sv
module srcdiv_cfg_reg
    import srcdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] wr_mask,
    output cfg_t              cfg_q,
    output cfg_t              cfg_d
);

    logic [WORD_W-1:0] merged;

    // Masked merge: a bit with mask 0 keeps its stored value.
    always_comb begin
        merged = (cfg_to_word(cfg_q) & ~wr_mask) | (wr_data & wr_mask);
        cfg_d  = wr_en ? word_to_cfg(merged) : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else
            cfg_q <= cfg_d;
    end

endmodule

// File: rtl/srcdiv_src_mux.sv
module srcdiv_src_mux #(
    parameter int N_SRC = 4,
    parameter int S_W   = 2
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [S_W-1:0]   sel,
    output logic             tick
);

    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ticks[g] && (sel == S_W'(g));
    end

    assign tick = |hit;

endmodule

// File: rtl/srcdiv_tick_div.sv
module srcdiv_tick_div
    import srcdiv_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_n,
    input  logic             in_tick,
    output logic             out_tick
);

    dv_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] n_q, n_d;
    logic             last;

    assign last = (cnt_q == (n_q - CNT_W'(1)));

    // Next state: load-to-pass, load-to-count, or hold.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        n_d     = n_q;
        if (load) begin
            n_d     = load_n;
            cnt_d   = '0;
            state_d = (load_n <= CNT_W'(1)) ? DV_PASS : DV_COUNT;
        end else begin
            unique case (state_q)
                DV_PASS:  cnt_d = '0;
                DV_COUNT: if (in_tick) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
                default:  cnt_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DV_PASS;
            cnt_q   <= '0;
            n_q     <= CNT_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            n_q     <= n_d;
        end
    end

    // Outputs are suppressed in a load cycle.
    always_comb begin
        out_tick = 1'b0;
        unique case (state_q)
            DV_PASS:  out_tick = in_tick && !load;
            DV_COUNT: out_tick = in_tick && last && !load;
            default:  out_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/srcdiv_top.sv
module srcdiv_top
    import srcdiv_pkg::*;
#(
    parameter bit POW2_RATIO = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic [31:0]        wr_mask,
    output logic [31:0]        rd_data,
    input  logic [3:0]         src_tick,
    output logic               out_tick
);

    cfg_t             cfg_q, cfg_d;
    logic             sel_tick;
    logic             pre_tick;
    logic [DIV_W-1:0] pre_n;
    logic [DIV_W-1:0] rat_n;

    srcdiv_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d)
    );

    assign rd_data = cfg_to_word(cfg_q);

    srcdiv_src_mux #(.N_SRC(NUM_SRC), .S_W(SEL_W)) u_mux (
        .ticks (src_tick),
        .sel   (cfg_q.sel),
        .tick  (sel_tick)
    );

    // Divisors come from the post-write value so the stages reload consistently.
    assign pre_n = pre_factor(cfg_d);
    assign rat_n = ratio_factor(cfg_d, POW2_RATIO);

    srcdiv_tick_div #(.CNT_W(DIV_W)) u_prediv (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_n   (pre_n),
        .in_tick  (sel_tick),
        .out_tick (pre_tick)
    );

    srcdiv_tick_div #(.CNT_W(DIV_W)) u_ratdiv (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_n   (rat_n),
        .in_tick  (pre_tick),
        .out_tick (out_tick)
    );

endmodule

// File: rtl/srcdiv_chk.sv
module srcdiv_chk
    import srcdiv_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_mask,
    input logic [31:0] rd_data,
    input logic [3:0]  src_tick,
    input logic        out_tick
);

    // R7
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~DEF_MASK) == 32'h0);

    // R1
    reset_word_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd_data == 32'h0001_0000);

    // R6
    src_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mask == SEL_MASK) |=>
            ((rd_data & ~SEL_MASK) == ($past(rd_data) & ~SEL_MASK)));

    // R9
    write_silent_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !out_tick);

    // R8
    out_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_tick |-> src_tick[rd_data[17:16]]);

    // R8
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_data[5:4] == 2'd0 &&
         (rd_data[17:16] != 2'd2 || rd_data[12:8] == 5'd0))
            |-> out_tick == src_tick[rd_data[17:16]]);

endmodule

bind srcdiv_top srcdiv_chk u_chk (.*);

// File: tb/srcdiv_top_bench.sv
module srcdiv_top_bench;

    typedef struct packed {
        logic [1:0]  sel;
        logic [4:0]  pre;
        logic [1:0]  ratio;
        logic [15:0] d_lin;
        logic [15:0] d_p2;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'd0,  2'd0, 16'd1,   16'd1},
        '{2'd1, 5'd7,  2'd1, 16'd2,   16'd2},
        '{2'd2, 5'd4,  2'd2, 16'd15,  16'd20},
        '{2'd3, 5'd31, 2'd3, 16'd4,   16'd8},
        '{2'd2, 5'd31, 2'd3, 16'd128, 16'd256},
        '{2'd2, 5'd0,  2'd1, 16'd2,   16'd2},
        '{2'd0, 5'd3,  2'd2, 16'd3,   16'd4},
        '{2'd1, 5'd0,  2'd3, 16'd4,   16'd8}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] wr_mask;
    logic [3:0]  src_tick;
    logic [31:0] rd_lin, rd_p2;
    logic        out_lin, out_p2;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    srcdiv_top #(.POW2_RATIO(1'b0)) u_srcdiv_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_data(rd_lin), .src_tick(src_tick), .out_tick(out_lin)
    );

    srcdiv_top #(.POW2_RATIO(1'b1)) u_srcdiv_top_p2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_data(rd_p2), .src_tick(src_tick), .out_tick(out_p2)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Distinct rates: src0 every 7, src1 every cycle, src2 every 2, src3 every 3.
    function automatic logic [3:0] gen_ticks(input int c);
        return {(c % 3 == 1), (c % 2 == 0), 1'b1, (c % 7 == 0)};
    endfunction

    task automatic write_reg(input logic [31:0] d, input logic [31:0] m);
        @(posedge clk);
        #1;
        wr_en = 1'b1; wr_data = d; wr_mask = m; src_tick = 4'hF;
        @(negedge clk);
        check(!out_lin && !out_p2, "R9 write gate", {out_lin, out_p2}, 0);
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_mask = '0; src_tick = '0;
    endtask

    task automatic run_window(input int n, input int sel, input int d_lin, input int d_p2,
                              input string tag_lin, input string tag_p2);
        int st = 0, ol = 0, op = 0, fl = -1, fp = -1;
        repeat (n) begin
            @(posedge clk);
            #1;
            src_tick = gen_ticks(cyc);
            cyc++;
            @(negedge clk);
            if (src_tick[sel]) st++;
            if (out_lin) begin ol++; if (fl < 0) fl = st; end
            if (out_p2)  begin op++; if (fp < 0) fp = st; end
        end
        @(posedge clk);
        #1;
        src_tick = '0;
        check(ol == st / d_lin, tag_lin, ol, st / d_lin);
        check(op == st / d_p2, tag_p2, op, st / d_p2);
        if (st >= d_lin) check(fl == d_lin, "R9 first output lin", fl, d_lin);
        if (st >= d_p2)  check(fp == d_p2,  "R9 first output p2", fp, d_p2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; wr_mask = '0; src_tick = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset word in both variants
        check(rd_lin == 32'h0001_0000, "R1 reset lin", rd_lin, 32'h0001_0000);
        check(rd_p2  == 32'h0001_0000, "R1 reset p2",  rd_p2,  32'h0001_0000);
        // R8 unity division passes source 1 straight through
        run_window(20, 1, 1, 1, "R8 pass lin", "R8 pass p2");

        // R7 undefined bits stay zero
        write_reg(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge clk);
        check(rd_lin == 32'h0003_1F30, "R7 undefined bits", rd_lin, 32'h0003_1F30);
        // R6 source-only write, R2 readback
        write_reg(32'h0000_0000, 32'h0003_0000);
        @(negedge clk);
        check(rd_lin == 32'h0000_1F30, "R6 R2 source-only write", rd_lin, 32'h0000_1F30);
        // R6 fully masked write changes nothing
        write_reg(32'hFFFF_FFFF, 32'h0000_0000);
        @(negedge clk);
        check(rd_lin == 32'h0000_1F30, "R6 masked write", rd_lin, 32'h0000_1F30);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] w;
            w = {14'd0, VECS[i].sel, 3'd0, VECS[i].pre, 2'd0, VECS[i].ratio, 4'd0};
            write_reg(w, 32'hFFFF_FFFF);
            @(negedge clk);
            check(rd_lin == w, "R2 readback", rd_lin, w);
            if (VECS[i].sel == 2'd2)
                run_window(2000, int'(VECS[i].sel), int'(VECS[i].d_lin), int'(VECS[i].d_p2),
                           "R3 R4 R10 lin ratio", "R3 R5 R10 p2 ratio");
            else
                run_window(2000, int'(VECS[i].sel), int'(VECS[i].d_lin), int'(VECS[i].d_p2),
                           "R2 R4 R10 lin ratio", "R2 R5 R10 p2 ratio");
        end

        // R9 write in the middle of a period restarts the count
        write_reg(32'h0002_0300, 32'hFFFF_FFFF);
        run_window(5, 2, 4, 4, "R3 partial lin", "R3 partial p2");
        write_reg(32'h0002_0300, 32'hFFFF_FFFF);
        run_window(40, 2, 4, 4, "R9 restart lin", "R9 restart p2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule